// File: doc/BRIEF.md
# Page-Bounded Transfer Segmenter

This block takes one storage read or write command and cuts it into host-memory transfers. No transfer crosses a host memory page boundary. A command carries five things: a first host pointer, a second host pointer, a byte count, a starting storage byte offset and a direction code. The block checks the command. It then issues the first piece at the first pointer. Each piece runs from its host address up to the next page boundary, or up to the end of the data if that comes first.

Once the first piece is acknowledged, the block decides how to use the second pointer, based on how many bytes are left:
- If at most one page remains, the second pointer is the host address of the next piece.
- If more than one page remains, the second pointer is handed to a separate list-walking stage, together with the remaining count and the storage offset.

Each command ends with a single-cycle done pulse that carries a success flag. Only one request is outstanding at a time. Both the data mover and the list walker are reached through valid/acknowledge ports.

Top module: `prp_chunk_segmenter`

## Requirements
- R1: A command with a byte count of zero produces a done pulse with `done_ok` low on the cycle after acceptance, and no transfer or list request is issued.
- R2: Each transfer length equals PAGE_BYTES minus (host address modulo PAGE_BYTES). If the bytes still outstanding are fewer, the length is that count instead. The length is never zero and never crosses a page.
- R3: Direction code 2'b01 is a read, moving storage data to host memory; its transfers show `dma_to_host` = 1. Direction code 2'b10 is a write, moving host data to storage; its transfers show `dma_to_host` = 0.
- R4: Direction codes 2'b00 and 2'b11 produce a done pulse with `done_ok` low on the cycle after acceptance, and no transfer or list request is issued.
- R5: Each transfer's storage offset is the command offset plus the lengths of all earlier transfers of that command. The remaining count drops by each acknowledged length.
- R6: The first transfer uses the first host pointer. If bytes remain after it and they amount to at most PAGE_BYTES, the next transfer uses the second pointer directly.
- R7: If more than PAGE_BYTES remain after the first transfer, the block raises a list request instead. That request carries the second pointer, the remaining count and the advanced offset. After the list acknowledge, the done pulse follows with `done_ok` high.
- R8: At most one of the transfer request and the list request is pending at a time. A pending transfer keeps its address, offset and length stable until it is acknowledged. `cmd_ready` is low while the block is busy.
- R9: When an acknowledged transfer brings the remaining count to zero, the done pulse with `done_ok` high appears on the next cycle.
- R10: If the transfer at the second pointer still leaves bytes outstanding (the second pointer is not aligned to a page), the command ends with `done_ok` low.
- R11: After reset, `cmd_ready` is high and `dma_req_valid`, `list_req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on valid |
| cmd_dir | input | 2 | Direction code: 01 read, 10 write |
| cmd_ptr1 | input | AW | First host pointer |
| cmd_ptr2 | input | AW | Second host pointer |
| cmd_bytes | input | LW | Total byte count |
| cmd_offs | input | OW | Starting storage byte offset |
| dma_req_valid | output | 1 | Transfer request pending |
| dma_ack | input | 1 | Transfer accepted and completed |
| dma_addr | output | AW | Host address of the transfer |
| dma_offs | output | OW | Storage offset of the transfer |
| dma_len | output | LW | Transfer length in bytes |
| dma_to_host | output | 1 | 1: storage to host, 0: host to storage |
| list_req_valid | output | 1 | List-walk handoff pending |
| list_ack | input | 1 | List stage took the handoff |
| list_ptr | output | AW | Pointer-list base (second pointer) |
| list_bytes | output | LW | Bytes remaining for the list stage |
| list_offs | output | OW | Storage offset for the list stage |
| done | output | 1 | One-cycle end-of-command pulse |
| done_ok | output | 1 | Status with done: 1 success, 0 failure |

## Verification
The bench targets the edge cases of pointer selection. When exactly one page remains after the first piece, the command must still take the direct second-pointer route. One byte more must switch it to the list handoff. A design with an off-by-one comparison swaps these two outcomes.

A first pointer that sits exactly one piece short of a page boundary checks the clipping. If the modulo or the minimum is computed wrongly, the piece either crosses the page or has the wrong length, and the storage offset then drifts on the next piece.

Zero-length commands and both illegal direction codes must finish with a failure and no traffic. A misaligned second pointer must fail rather than report success with bytes left over.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [1:0] DIR_READ  = 2'b01;
  localparam logic [1:0] DIR_WRITE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER1 = 2'd1,
    ST_XFER2 = 2'd2,
    ST_LIST  = 2'd3
  } seg_state_e;
endpackage

// File: rtl/pcs_chunk_len.sv
module pcs_chunk_len #(
  parameter int AW         = 32,
  parameter int LW         = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] remain,
  output logic [LW-1:0] len
);
  localparam int POW = $clog2(PAGE_BYTES);

  logic [LW-1:0] span;

  always_comb begin
    span = LW'(PAGE_BYTES) - LW'(addr[POW-1:0]);
    len  = (remain < span) ? remain : span;
  end
endmodule

// File: rtl/pcs_cmd_check.sv
module pcs_cmd_check #(
  parameter int LW = 24
) (
  input  logic [1:0]    dir,
  input  logic [LW-1:0] bytes,
  output logic          legal,
  output logic          to_host
);
  import pcs_pkg::*;

  always_comb begin
    to_host = (dir == DIR_READ);
    legal   = (bytes != '0) && ((dir == DIR_READ) || (dir == DIR_WRITE));
  end
endmodule

// File: rtl/prp_chunk_segmenter.sv
module prp_chunk_segmenter #(
  parameter int AW         = 32,
  parameter int LW         = 24,
  parameter int OW         = 40,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_dir,
  input  logic [AW-1:0] cmd_ptr1,
  input  logic [AW-1:0] cmd_ptr2,
  input  logic [LW-1:0] cmd_bytes,
  input  logic [OW-1:0] cmd_offs,
  output logic          dma_req_valid,
  input  logic          dma_ack,
  output logic [AW-1:0] dma_addr,
  output logic [OW-1:0] dma_offs,
  output logic [LW-1:0] dma_len,
  output logic          dma_to_host,
  output logic          list_req_valid,
  input  logic          list_ack,
  output logic [AW-1:0] list_ptr,
  output logic [LW-1:0] list_bytes,
  output logic [OW-1:0] list_offs,
  output logic          done,
  output logic          done_ok
);
  import pcs_pkg::*;

  localparam int NPTR = 2;
  localparam logic [LW-1:0] PAGE_LEN = LW'(PAGE_BYTES);

  seg_state_e    state;
  logic [LW-1:0] rem_q;
  logic [AW-1:0] ptr2_q;

  logic          cmd_legal;
  logic          cmd_to_host;
  logic [LW-1:0] rem_next;
  logic [OW-1:0] offs_next;

  logic [AW-1:0] calc_addr [NPTR];
  logic [LW-1:0] calc_rem  [NPTR];
  logic [LW-1:0] calc_len  [NPTR];

  pcs_cmd_check #(.LW(LW)) u_check (
    .dir     (cmd_dir),
    .bytes   (cmd_bytes),
    .legal   (cmd_legal),
    .to_host (cmd_to_host)
  );

  assign rem_next  = rem_q - dma_len;
  assign offs_next = dma_offs + OW'(dma_len);

  // Piece 0 is sized from the incoming command, piece 1 from the second pointer
  assign calc_addr[0] = cmd_ptr1;
  assign calc_rem[0]  = cmd_bytes;
  assign calc_addr[1] = ptr2_q;
  assign calc_rem[1]  = rem_next;

  for (genvar g = 0; g < NPTR; g++) begin : g_chunk
    pcs_chunk_len #(
      .AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES)
    ) u_len (
      .addr   (calc_addr[g]),
      .remain (calc_rem[g]),
      .len    (calc_len[g])
    );
  end

  assign cmd_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      rem_q          <= '0;
      ptr2_q         <= '0;
      dma_req_valid  <= 1'b0;
      dma_addr       <= '0;
      dma_offs       <= '0;
      dma_len        <= '0;
      dma_to_host    <= 1'b0;
      list_req_valid <= 1'b0;
      list_ptr       <= '0;
      list_bytes     <= '0;
      list_offs      <= '0;
      done           <= 1'b0;
      done_ok        <= 1'b0;
    end else begin
      done    <= 1'b0;
      done_ok <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (!cmd_legal) begin
              done <= 1'b1;
            end else begin
              dma_req_valid <= 1'b1;
              dma_addr      <= cmd_ptr1;
              dma_offs      <= cmd_offs;
              dma_len       <= calc_len[0];
              dma_to_host   <= cmd_to_host;
              rem_q         <= cmd_bytes;
              ptr2_q        <= cmd_ptr2;
              state         <= ST_XFER1;
            end
          end
        end
        ST_XFER1: begin
          if (dma_ack) begin
            dma_req_valid <= 1'b0;
            rem_q         <= rem_next;
            if (rem_next == '0) begin
              done    <= 1'b1;
              done_ok <= 1'b1;
              state   <= ST_IDLE;
            end else if (rem_next <= PAGE_LEN) begin
              dma_req_valid <= 1'b1;
              dma_addr      <= ptr2_q;
              dma_offs      <= offs_next;
              dma_len       <= calc_len[1];
              state         <= ST_XFER2;
            end else begin
              list_req_valid <= 1'b1;
              list_ptr       <= ptr2_q;
              list_bytes     <= rem_next;
              list_offs      <= offs_next;
              state          <= ST_LIST;
            end
          end
        end
        ST_XFER2: begin
          if (dma_ack) begin
            dma_req_valid <= 1'b0;
            rem_q         <= rem_next;
            done          <= 1'b1;
            done_ok       <= (rem_next == '0);
            state         <= ST_IDLE;
          end
        end
        ST_LIST: begin
          if (list_ack) begin
            list_req_valid <= 1'b0;
            done           <= 1'b1;
            done_ok        <= 1'b1;
            state          <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcs_sva.sv
module pcs_sva #(
  parameter int AW         = 32,
  parameter int LW         = 24,
  parameter int OW         = 40,
  parameter int PAGE_BYTES = 4096
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_dir,
  input logic [LW-1:0] cmd_bytes,
  input logic          dma_req_valid,
  input logic          dma_ack,
  input logic [AW-1:0] dma_addr,
  input logic [OW-1:0] dma_offs,
  input logic [LW-1:0] dma_len,
  input logic          list_req_valid,
  input logic          done,
  input logic          done_ok
);
  localparam int POW = $clog2(PAGE_BYTES);

  logic [LW:0] page_end;
  assign page_end = (LW+1)'(dma_addr[POW-1:0]) + (LW+1)'(dma_len);

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    !(dma_req_valid && list_req_valid));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid || list_req_valid) |-> !cmd_ready);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && !dma_ack) |=>
      (dma_req_valid && $stable(dma_addr) && $stable(dma_len) && $stable(dma_offs)));

  a_r2_no_page_cross: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> ((dma_len != '0) && (page_end <= (LW+1)'(PAGE_BYTES))));

  a_r5_offset_advance: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && dma_ack) |=>
      (!dma_req_valid || (dma_offs == $past(dma_offs) + OW'($past(dma_len)))));

  a_r1_zero_len_fails: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_bytes == '0)) |=>
      (done && !done_ok && !dma_req_valid && !list_req_valid));

  a_r4_bad_dir_fails: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && ((cmd_dir == 2'b00) || (cmd_dir == 2'b11))) |=>
      (done && !done_ok && !dma_req_valid && !list_req_valid));
endmodule

bind prp_chunk_segmenter pcs_sva #(
  .AW(AW), .LW(LW), .OW(OW), .PAGE_BYTES(PAGE_BYTES)
) u_sva (
  .clk            (clk),
  .rst            (rst),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .cmd_dir        (cmd_dir),
  .cmd_bytes      (cmd_bytes),
  .dma_req_valid  (dma_req_valid),
  .dma_ack        (dma_ack),
  .dma_addr       (dma_addr),
  .dma_offs       (dma_offs),
  .dma_len        (dma_len),
  .list_req_valid (list_req_valid),
  .done           (done),
  .done_ok        (done_ok)
);

// File: tb/tb_prp_chunk_segmenter.sv
module tb_prp_chunk_segmenter;
  localparam int AW   = 32;
  localparam int LW   = 24;
  localparam int OW   = 40;
  localparam int PAGE = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_dir = '0;
  logic [AW-1:0] cmd_ptr1 = '0;
  logic [AW-1:0] cmd_ptr2 = '0;
  logic [LW-1:0] cmd_bytes = '0;
  logic [OW-1:0] cmd_offs = '0;
  logic          dma_req_valid;
  logic          dma_ack = 1'b0;
  logic [AW-1:0] dma_addr;
  logic [OW-1:0] dma_offs;
  logic [LW-1:0] dma_len;
  logic          dma_to_host;
  logic          list_req_valid;
  logic          list_ack = 1'b0;
  logic [AW-1:0] list_ptr;
  logic [LW-1:0] list_bytes;
  logic [OW-1:0] list_offs;
  logic          done;
  logic          done_ok;

  always #2 clk = ~clk;

  prp_chunk_segmenter #(.AW(AW), .LW(LW), .OW(OW), .PAGE_BYTES(PAGE)) dut (.*);

  typedef struct {
    int          kind;   // 0 transfer, 1 list handoff, 2 done
    longint      addr;
    longint      offs;
    longint      len;
    bit          th;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int lat   = 0;
  int cycles = 0;

  task automatic chk(string req, longint act, longint expv, string what);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t mk(int k, longint a, longint o, longint l, bit th, string req);
    exp_t e;
    e.kind = k; e.addr = a; e.offs = o; e.len = l; e.th = th; e.req = req;
    return e;
  endfunction

  function automatic longint piece(longint a, longint rem);
    longint span;
    span = PAGE - (a % PAGE);
    return (rem < span) ? rem : span;
  endfunction

  // Driver: builds the expected sequence from the requirements, then offers the command
  task automatic run_cmd(logic [1:0] dir, longint p1, longint p2, longint n, longint offs,
                         string req);
    longint rem, o, c;
    bit th;
    rem = n; o = offs;
    th = (dir == 2'b01);
    if (n == 0 || dir == 2'b00 || dir == 2'b11) begin
      exp_q.push_back(mk(2, 0, 0, 0, 1'b0, req));
    end else begin
      c = piece(p1, rem);
      exp_q.push_back(mk(0, p1, o, c, th, req));
      rem -= c; o += c;
      if (rem == 0) begin
        exp_q.push_back(mk(2, 0, 0, 0, 1'b1, req));
      end else if (rem <= PAGE) begin
        c = piece(p2, rem);
        exp_q.push_back(mk(0, p2, o, c, th, req));
        rem -= c;
        exp_q.push_back(mk(2, 0, 0, 0, rem == 0, req));
      end else begin
        exp_q.push_back(mk(1, p2, o, rem, th, req));
        exp_q.push_back(mk(2, 0, 0, 0, 1'b1, req));
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = dir; cmd_ptr1 = AW'(p1); cmd_ptr2 = AW'(p2);
    cmd_bytes = LW'(n); cmd_offs = OW'(offs);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Transfer and list responders
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rst || dma_ack) begin dma_ack = 1'b0; cnt = 0; end
      else if (dma_req_valid) begin
        if (cnt >= lat) dma_ack = 1'b1; else cnt++;
      end
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rst || list_ack) begin list_ack = 1'b0; cnt = 0; end
      else if (list_req_valid) begin
        if (cnt >= lat) list_ack = 1'b1; else cnt++;
      end
    end
  end

  // Monitor: pops the scoreboard on every handshake and done pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (!rst && dma_req_valid && dma_ack) begin
        if (exp_q.size() == 0) chk("R8", 1, 0, "unexpected transfer");
        else begin
          e = exp_q.pop_front();
          chk(e.req, 0, e.kind, "event kind (transfer) R6");
          chk(e.req, dma_addr, e.addr, "transfer addr R6");
          chk(e.req, dma_offs, e.offs, "transfer offset R5");
          chk(e.req, dma_len, e.len, "transfer length R2");
          chk(e.req, dma_to_host, e.th, "direction R3");
        end
      end
      if (!rst && list_req_valid && list_ack) begin
        if (exp_q.size() == 0) chk("R7", 1, 0, "unexpected list handoff");
        else begin
          e = exp_q.pop_front();
          chk(e.req, 1, e.kind, "event kind (list) R7");
          chk(e.req, list_ptr, e.addr, "list pointer R7");
          chk(e.req, list_offs, e.offs, "list offset R7");
          chk(e.req, list_bytes, e.len, "list bytes R7");
        end
      end
      if (!rst && done) begin
        if (exp_q.size() == 0) chk("R9", 1, 0, "unexpected done");
        else begin
          e = exp_q.pop_front();
          chk(e.req, 2, e.kind, "event kind (done) R9");
          chk(e.req, done_ok, e.th, "done status");
        end
      end
    end
  end

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R11", cmd_ready, 1, "ready after reset");
    chk("R11", dma_req_valid, 0, "dma valid after reset");
    chk("R11", list_req_valid, 0, "list valid after reset");
    chk("R11", done, 0, "done after reset");

    run_cmd(2'b01, 'h1000, 'h9000, 0, 'h40, "R1");           // zero length
    run_cmd(2'b00, 'h1000, 'h9000, 'h100, 0, "R4");          // bad dir 00
    run_cmd(2'b11, 'h1000, 'h9000, 'h100, 0, "R4");          // bad dir 11
    run_cmd(2'b01, 'h2000, 'h9000, 100, 'h123, "R3");        // read, single piece
    run_cmd(2'b10, 'h1F00, 'h9000, 'h100, 'h10, "R2");       // write, ends on boundary
    lat = 3;
    run_cmd(2'b10, 'h1F00, 'h8000, 'h500, 'h700, "R6");      // clipped then second pointer
    run_cmd(2'b01, 'h2000, 'hA000, 'h1800, 0, "R5");         // full page then remainder
    run_cmd(2'b01, 'h0000, 'h5000, 'h2000, 'h55, "R6");      // exactly one page left
    lat = 1;
    run_cmd(2'b01, 'h0000, 'h5000, 'h2001, 'h66, "R7");      // one page plus one byte
    run_cmd(2'b10, 'h3800, 'hC000, 'h2000, 'h1000, "R7");    // list handoff
    run_cmd(2'b01, 'h2000, 'h6C00, 'h1800, 0, "R10");        // misaligned second pointer
    lat = 0;
    run_cmd(2'b01, 'h4FFF, 'h7000, 1, 'h9, "R9");            // last byte of a page

    repeat (4) @(negedge clk);
    chk("R9", exp_q.size(), 0, "scoreboard drained");
    chk("R11", cmd_ready, 1, "idle at end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule